// File: doc/BRIEF.md
# Over-Temperature Alert Fault Queue

This block decides the level of an over-temperature alert line after each finished temperature conversion. Each conversion arrives as a one-cycle strobe carrying a signed two's-complement reading. The block compares that reading with a high limit and a low limit, which use the same number format. It asserts or releases the alert only after a selectable number of conversions in a row have met the condition it is currently watching.

There are two alert modes. In comparator mode the alert follows a hysteresis band: it is raised at or above the high limit and dropped below the low limit. In interrupt mode each crossing raises a latched event. The event stays up until a register read, a finished alert-response transaction or a shutdown command clears it. After a clear the block watches the opposite limit.

A separate alarm status bit always follows the comparator behaviour. A response status bit tells an alert-response responder whether the pending event came from the high limit or from the low limit. A general-call reset pulse returns all internal state to its power-up values.

The conversion input is a valid-only stream. The block accepts every beat in the cycle it is presented and never applies back-pressure, so there is no ready signal. Control and status pins are plain levels or pulses. Every output is registered and changes in the cycle after the clock edge that takes the strobe or the pulse.

Top module: `thermal_alert_queue`

## Requirements
- R1: `fault_sel` sets the run length of consecutive qualifying conversions: 2'b00 means 1, 2'b01 means 2, 2'b10 means 4 and 2'b11 means 6. Any conversion that fails the watched condition restarts the run from zero.
- R2: In comparator mode (`irq_mode`=0) the alert becomes active after a full run of readings greater than or equal to `lim_hi`. A reading equal to the limit counts.
- R3: In comparator mode an active alert stays active for readings between the limits and for readings equal to `lim_lo`. It becomes inactive only after a full run of readings strictly below `lim_lo`.
- R4: In interrupt mode (`irq_mode`=1) the alert becomes active after a full run at or above `lim_hi`. It then stays active whatever the readings are, until a pulse on `clr_read`, `clr_resp` or `clr_shdn`.
- R5: In interrupt mode, after a clear the block watches `lim_lo`. A full run strictly below it raises the alert again, and the same three pulses clear that event. After that the block watches `lim_hi` again.
- R6: With `alert_pol`=0 the alert output is driven low when active and high when idle. With `alert_pol`=1 it is driven high when active.
- R7: `alarm_stat` is 1 when there is no comparator alarm and 0 while there is one (the sense is reversed when `alert_pol`=1). It follows the comparator rules of R2 and R3 in both modes.
- R8: `resp_stat` equals `alert_pol` while the block watches or holds a high-limit event. It equals the inverse of `alert_pol` while the block watches or holds a low-limit event.
- R9: A `gen_call_rst` pulse clears both alarm states and the fault run, and returns the interrupt logic to watching the high limit.
- R10: Outside a `conv_valid` cycle the reading has no effect. Clear pulses have no effect in comparator mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is present |
| conv_temp | input | TW | Signed reading, 0.0625 °C per LSB |
| lim_hi | input | TW | Signed high limit |
| lim_lo | input | TW | Signed low limit |
| fault_sel | input | 2 | Consecutive-fault count select |
| irq_mode | input | 1 | 0 comparator mode, 1 interrupt mode |
| alert_pol | input | 1 | Alert polarity, 1 = active high |
| clr_read | input | 1 | Clear pulse from a register read |
| clr_resp | input | 1 | Clear pulse from a finished alert-response transaction |
| clr_shdn | input | 1 | Clear pulse from a shutdown command |
| gen_call_rst | input | 1 | General-call reset pulse |
| alert_o | output | 1 | Alert line level |
| alarm_stat | output | 1 | Comparator alarm status bit |
| resp_stat | output | 1 | Limit-source bit for alert responses |

## Verification
The bench builds the block with the default TW of 13, the extended-range width. This lets it use a 150 °C reading (2400 LSB) and a -55 °C reading (-880 LSB) as well as the default limits of 80 °C and 75 °C. Values sit exactly on each limit to pin down the at-or-above and strictly-below edges. All four fault counts are exercised, including runs broken by a single miss. Mode and polarity changes are made while an alarm is held, which shows the status bit staying on comparator rules while the interrupt event stays latched.

// File: rtl/fq_pkg.sv
package fq_pkg;

  localparam int unsigned RUN_W = 3;

  typedef enum logic [1:0] {
    RUN_ONE  = 2'b00,
    RUN_TWO  = 2'b01,
    RUN_FOUR = 2'b10,
    RUN_SIX  = 2'b11
  } run_sel_e;

  function automatic logic [RUN_W-1:0] run_need(input logic [1:0] sel);
    case (run_sel_e'(sel))
      RUN_ONE:  run_need = RUN_W'(1);
      RUN_TWO:  run_need = RUN_W'(2);
      RUN_FOUR: run_need = RUN_W'(4);
      default:  run_need = RUN_W'(6);
    endcase
  endfunction

endpackage

// File: rtl/fq_consec.sv
module fq_consec #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          hit,
  input  logic          restart,
  input  logic [CW-1:0] need,
  output logic          fire
);
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_inc;

  assign run_inc = run_q + CW'(1);
  assign fire    = step & hit & ~restart & (run_inc >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (restart)           run_q <= '0;
    else if (step) begin
      if (!hit || fire)         run_q <= '0;
      else                      run_q <= run_inc;
    end
  end

  AST_RUN_BELOW_SIX: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(6)); // R1
endmodule

// File: rtl/fq_cmp_track.sv
module fq_cmp_track #(
  parameter int unsigned TW = 13,
  parameter int unsigned CW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_valid,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] hi,
  input  logic signed [TW-1:0] lo,
  input  logic [CW-1:0]        need,
  input  logic                 gc,
  output logic                 in_alarm
);
  logic hit, fire;

  assign hit = in_alarm ? (temp < lo) : (temp >= hi);

  fq_consec #(.CW(CW)) u_run (
    .clk(clk), .rst_n(rst_n), .step(conv_valid), .hit(hit),
    .restart(gc), .need(need), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_alarm <= 1'b0;
    else if (gc)    in_alarm <= 1'b0;
    else if (fire)  in_alarm <= ~in_alarm;
  end

  AST_CMP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_alarm) |-> $past(conv_valid && (temp >= hi))); // R2
  AST_CMP_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_alarm) |-> ($past(gc) || $past(conv_valid && (temp < lo)))); // R3
endmodule

// File: rtl/fq_int_track.sv
module fq_int_track #(
  parameter int unsigned TW = 13,
  parameter int unsigned CW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 conv_valid,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] hi,
  input  logic signed [TW-1:0] lo,
  input  logic [CW-1:0]        need,
  input  logic                 clr,
  input  logic                 gc,
  output logic                 pending,
  output logic                 watch_low
);
  logic hold, hit, fire, step;

  assign hold = gc | ~enable;
  assign step = conv_valid & enable & ~pending;
  assign hit  = watch_low ? (temp < lo) : (temp >= hi);

  fq_consec #(.CW(CW)) u_run (
    .clk(clk), .rst_n(rst_n), .step(step), .hit(hit),
    .restart(hold | pending), .need(need), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      watch_low <= 1'b0;
    end else if (hold) begin
      pending   <= 1'b0;
      watch_low <= 1'b0;
    end else if (pending && clr) begin
      pending   <= 1'b0;
      watch_low <= ~watch_low;
    end else if (fire) begin
      pending   <= 1'b1;
    end
  end

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pending && !clr && !gc) |=> pending); // R4
  AST_INT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pending) && $past(enable) && !$past(gc)) |-> (watch_low != $past(watch_low))); // R5
endmodule

// File: rtl/thermal_alert_queue.sv
module thermal_alert_queue #(
  parameter int unsigned TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  input  logic [TW-1:0] conv_temp,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic [1:0]    fault_sel,
  input  logic          irq_mode,
  input  logic          alert_pol,
  input  logic          clr_read,
  input  logic          clr_resp,
  input  logic          clr_shdn,
  input  logic          gen_call_rst,
  output logic          alert_o,
  output logic          alarm_stat,
  output logic          resp_stat
);
  import fq_pkg::*;

  logic signed [TW-1:0] t_s, hi_s, lo_s;
  logic [RUN_W-1:0]     need;
  logic                 cmp_alarm, int_pend, int_low, active;

  assign t_s  = $signed(conv_temp);
  assign hi_s = $signed(lim_hi);
  assign lo_s = $signed(lim_lo);
  assign need = run_need(fault_sel);

  fq_cmp_track #(.TW(TW), .CW(RUN_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .temp(t_s),
    .hi(hi_s), .lo(lo_s), .need(need), .gc(gen_call_rst), .in_alarm(cmp_alarm)
  );

  fq_int_track #(.TW(TW), .CW(RUN_W)) u_int (
    .clk(clk), .rst_n(rst_n), .enable(irq_mode), .conv_valid(conv_valid),
    .temp(t_s), .hi(hi_s), .lo(lo_s), .need(need),
    .clr(clr_read | clr_resp | clr_shdn), .gc(gen_call_rst),
    .pending(int_pend), .watch_low(int_low)
  );

  assign active     = irq_mode ? int_pend : cmp_alarm;
  assign alert_o    = alert_pol ? active : ~active;
  assign alarm_stat = alert_pol ? cmp_alarm : ~cmp_alarm;
  assign resp_stat  = alert_pol ^ int_low;

  AST_GC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gen_call_rst) |-> (!cmp_alarm && !int_pend && !int_low)); // R9
  AST_CMP_IGNORES_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mode && !conv_valid && !gen_call_rst) |=> $stable(cmp_alarm)); // R10
endmodule

// File: tb/sim_thermal_alert_queue.sv
module sim_thermal_alert_queue;
  localparam int TW = 13;
  localparam logic [12:0] TH = 13'd1300, TE = 13'd1280, TM = 13'd1250,
                          TB = 13'd1200, TL = 13'd1100, TX = 13'd2400,
                          TN = 13'h1C90; // -880 = -55 C

  typedef struct packed {
    logic [1:0]  act;   // 0 conversion, 1 read clr, 2 response clr, 3 shutdown clr
    logic        mode;
    logic        pol;
    logic [1:0]  fs;
    logic [12:0] t;
    logic        ea;
    logic        es;
    logic        er;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    '{2'd0,1'b0,1'b0,2'd0,TM,1'b1,1'b1,1'b0}, // R2 between: idle
    '{2'd0,1'b0,1'b0,2'd0,TE,1'b0,1'b0,1'b0}, // R2 equal hi triggers
    '{2'd0,1'b0,1'b0,2'd0,TM,1'b0,1'b0,1'b0}, // R3 band holds
    '{2'd0,1'b0,1'b0,2'd0,TB,1'b0,1'b0,1'b0}, // R3 equal lo holds
    '{2'd0,1'b0,1'b0,2'd0,TL,1'b1,1'b1,1'b0}, // R3 below releases
    '{2'd0,1'b0,1'b0,2'd1,TH,1'b1,1'b1,1'b0}, // R1 count 2, 1 of 2
    '{2'd0,1'b0,1'b0,2'd1,TM,1'b1,1'b1,1'b0}, // R1 miss restarts
    '{2'd0,1'b0,1'b0,2'd1,TH,1'b1,1'b1,1'b0},
    '{2'd0,1'b0,1'b0,2'd1,TH,1'b0,1'b0,1'b0}, // R1 2 of 2
    '{2'd1,1'b0,1'b0,2'd1,TM,1'b0,1'b0,1'b0}, // R10 clr ignored in comparator
    '{2'd0,1'b0,1'b0,2'd1,TL,1'b0,1'b0,1'b0},
    '{2'd0,1'b0,1'b0,2'd1,TM,1'b0,1'b0,1'b0},
    '{2'd0,1'b0,1'b0,2'd1,TL,1'b0,1'b0,1'b0},
    '{2'd0,1'b0,1'b0,2'd1,TL,1'b1,1'b1,1'b0}, // R3 run of 2 below
    '{2'd0,1'b0,1'b0,2'd3,TH,1'b1,1'b1,1'b0}, // R1 count 6
    '{2'd0,1'b0,1'b0,2'd3,TH,1'b1,1'b1,1'b0},
    '{2'd0,1'b0,1'b0,2'd3,TH,1'b1,1'b1,1'b0},
    '{2'd0,1'b0,1'b0,2'd3,TH,1'b1,1'b1,1'b0},
    '{2'd0,1'b0,1'b0,2'd3,TH,1'b1,1'b1,1'b0},
    '{2'd0,1'b0,1'b0,2'd3,TH,1'b0,1'b0,1'b0}, // R1 sixth fires
    '{2'd0,1'b0,1'b1,2'd0,TN,1'b0,1'b0,1'b1}, // R6 pol1 idle low, negative reading
    '{2'd0,1'b0,1'b1,2'd0,TX,1'b1,1'b1,1'b1}, // R6 pol1 active high at 150 C
    '{2'd0,1'b1,1'b0,2'd0,TM,1'b1,1'b0,1'b0}, // R7 status keeps comparator alarm
    '{2'd0,1'b1,1'b0,2'd0,TH,1'b0,1'b0,1'b0}, // R4 interrupt high event
    '{2'd0,1'b1,1'b0,2'd0,TL,1'b0,1'b1,1'b0}, // R4 held; R7 status releases
    '{2'd1,1'b1,1'b0,2'd0,TL,1'b1,1'b1,1'b1}, // R4 read clear; R8 watch low
    '{2'd0,1'b1,1'b0,2'd0,TH,1'b1,1'b0,1'b1}, // R5 high ignored while watching low
    '{2'd0,1'b1,1'b0,2'd0,TL,1'b0,1'b1,1'b1}, // R5 low event
    '{2'd2,1'b1,1'b0,2'd0,TL,1'b1,1'b1,1'b0}, // R5 response clear
    '{2'd0,1'b1,1'b0,2'd0,TH,1'b0,1'b0,1'b0}, // R5 back on high
    '{2'd3,1'b1,1'b0,2'd0,TH,1'b1,1'b0,1'b1}, // R4 shutdown clear
    '{2'd0,1'b1,1'b1,2'd1,TL,1'b0,1'b1,1'b0}, // R8 pol1 low watch
    '{2'd0,1'b1,1'b1,2'd1,TL,1'b1,1'b0,1'b0}, // R5 run of 2 below
    '{2'd0,1'b1,1'b1,2'd1,TH,1'b1,1'b0,1'b0}, // R4 held
    '{2'd1,1'b1,1'b1,2'd1,TH,1'b0,1'b0,1'b1}  // R8 cleared, high watch
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_valid = 0, irq_mode = 0, alert_pol = 0;
  logic clr_read = 0, clr_resp = 0, clr_shdn = 0, gen_call_rst = 0;
  logic [TW-1:0] conv_temp = '0;
  logic [TW-1:0] lim_hi = 13'd1280, lim_lo = 13'd1200;
  logic [1:0] fault_sel = 2'd0;
  logic alert_o, alarm_stat, resp_stat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  thermal_alert_queue #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_temp(conv_temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .fault_sel(fault_sel), .irq_mode(irq_mode),
    .alert_pol(alert_pol), .clr_read(clr_read), .clr_resp(clr_resp),
    .clr_shdn(clr_shdn), .gen_call_rst(gen_call_rst), .alert_o(alert_o),
    .alarm_stat(alarm_stat), .resp_stat(resp_stat)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check3(input string tag, input logic ea, input logic es, input logic er);
    chk({tag, " alert_o"}, alert_o, ea);
    chk({tag, " alarm_stat"}, alarm_stat, es);
    chk({tag, " resp_stat"}, resp_stat, er);
  endtask

  task automatic apply(input logic [1:0] act, input logic m, input logic p,
                       input logic [1:0] fs, input logic [12:0] t);
    @(negedge clk);
    irq_mode = m; alert_pol = p; fault_sel = fs; conv_temp = t;
    conv_valid = (act == 2'd0);
    clr_read   = (act == 2'd1);
    clr_resp   = (act == 2'd2);
    clr_shdn   = (act == 2'd3);
    @(negedge clk);
    conv_valid = 0; clr_read = 0; clr_resp = 0; clr_shdn = 0;
  endtask

  task automatic gcall();
    @(negedge clk);
    gen_call_rst = 1;
    @(negedge clk);
    gen_call_rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check3("R6 reset state", 1'b1, 1'b1, 1'b0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].act, TBL[i].mode, TBL[i].pol, TBL[i].fs, TBL[i].t);
      check3($sformatf("vector %0d", i), TBL[i].ea, TBL[i].es, TBL[i].er);
    end
    // R1 / R9: count of 4 interrupted by a general call
    gcall();
    for (int k = 0; k < 3; k++) apply(2'd0, 1'b0, 1'b0, 2'd2, TH);
    check3("R1 three of four", 1'b1, 1'b1, 1'b0);
    gcall();
    for (int k = 0; k < 3; k++) apply(2'd0, 1'b0, 1'b0, 2'd2, TH);
    check3("R9 run restarted by general call", 1'b1, 1'b1, 1'b0);
    apply(2'd0, 1'b0, 1'b0, 2'd2, TH);
    check3("R1 fourth fires", 1'b0, 1'b0, 1'b0);
    // R9: general call clears a pending interrupt event
    apply(2'd0, 1'b1, 1'b0, 2'd0, TH);
    check3("R4 interrupt raised", 1'b0, 1'b0, 1'b0);
    gcall();
    check3("R9 general call clears", 1'b1, 1'b1, 1'b0);
    // R10: reading without a strobe is ignored
    @(negedge clk);
    irq_mode = 0; conv_temp = TX;
    repeat (4) @(negedge clk);
    check3("R10 no strobe no effect", 1'b1, 1'b1, 1'b0);
    apply(2'd0, 1'b0, 1'b0, 2'd0, TX);
    check3("R2 strobe takes reading", 1'b0, 1'b0, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule